// File: doc/BRIEF.md
# Parallel NOR Flash Write Sequencer with Completion Polling

This block sits on the host side of a parallel NOR flash. It takes one write request at a time: a word program, a sector erase, a block erase or a whole-array erase. It then plays the unlock prefix and the command cycles onto a simple bus. Each bus transfer is one stroke, qualified by `bus_valid` and completed by `bus_ready`. After the last command cycle the block reads the target location to watch for the end of the internal write.

It watches in one of two ways. In toggle mode it looks for a status bit that stops alternating between two reads. In data-polling mode it looks for the polled bit to take its final value. An apparent finish might be a read that raced the end of the write, so the block reads the location twice more before it accepts the finish. Only when both extra reads confirm does it report success. A programmable limit on failed status checks turns a write that never finishes into an error.

The request side is a valid/ready port. `req_ready` is high only while the block is idle, so a held `req_valid` simply waits, and the request fields must stay stable until the handshake. The result is a one-cycle `done_valid` pulse that carries `done_err`, with no back-pressure. On the flash side the block holds a transfer steady until the bus accepts it.

Top module: `nor_wr_poller`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. A request is taken on a cycle with `req_valid` and `req_ready` both high, and `req_ready` is low on the cycle after acceptance until the result pulse has been given.
- R2: A program request (`req_op`=0) issues four writes in this order: (5555h, AAh), (2AAAh, 55h), (5555h, A0h), (target, word).
- R3: A sector erase (`req_op`=1) or block erase (`req_op`=2) issues six writes: (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), then (target, 30h) for a sector or (target, 50h) for a block.
- R4: A whole-array erase (`req_op`=3) issues the same first five writes as R3, with (5555h, 10h) as the sixth.
- R5: Every status read after the command cycles is addressed to the request's target address.
- R6: With `req_toggle`=1, each status check is two reads, and it is an apparent finish when bit 6 is equal in both.
- R7: With `req_toggle`=0, each status check is one read. It is an apparent finish when bit 7 equals bit 7 of the programmed word, or equals 1 for any erase.
- R8: After an apparent finish the block makes two more reads of the target. Success is reported only when both show a finished status: bit 6 unchanged from the previous read in toggle mode, or bit 7 at its final value in data-polling mode. If either read fails, the check counts as failed and polling goes on.
- R9: `req_secid`=1 on a program request replaces the third command code with A5h and forces toggle mode, whatever `req_toggle` says.
- R10: Each failed status check is counted. When the count reaches `cfg_limit` (a limit of 0 acts as 1), the block ends the request with `done_err`=1.
- R11: Each accepted request gives exactly one `done_valid` pulse, one cycle wide, with `done_err`=0 on success.
- R12: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_we`, `bus_addr` and `bus_wdata` keep their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 whole-array erase |
| req_secid | input | 1 | Program targets the security-ID area |
| req_toggle | input | 1 | 1 toggle-bit polling, 0 data polling |
| req_addr | input | AW | Target word address |
| req_data | input | DW | Word to program |
| cfg_limit | input | TW | Failed status checks allowed before error |
| done_valid | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Completion is a timeout error |
| bus_valid | output | 1 | Bus transfer requested |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | AW | Transfer address |
| bus_wdata | output | DW | Write data |
| bus_ready | input | 1 | Transfer accepted; read data valid this cycle |
| bus_rdata | input | DW | Read data |

## Verification
A flash model in the bench answers status reads while it is busy for a chosen number of reads. The bench sweeps every operation against both polling modes, busy lengths from zero up, and bus stalls. This separates a correct command stream from a wrong one, and a correct finish from an early one. It also injects a single spurious "finished" read in the middle of the busy phase. A poller that skips the two confirming reads would then report success while the flash is still busy. Timeout runs with a long busy phase give exact read counts: the limit in data-polling mode, twice the limit in toggle mode. This tells apart the limit handling, the zero-limit case, and whether the security-ID flag really forces toggle mode.

// File: rtl/nor_poll_pkg.sv
package nor_poll_pkg;
  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_SECT  = 2'd1,
    OP_BLK   = 2'd2,
    OP_CHIP  = 2'd3
  } nor_op_e;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_CMD    = 3'd1,
    S_POLL_A = 3'd2,
    S_POLL_B = 3'd3,
    S_VER_A  = 3'd4,
    S_VER_B  = 3'd5,
    S_DONE   = 3'd6
  } poll_st_e;

  localparam logic [15:0] UNLK_ADDR_HI = 16'h5555;
  localparam logic [15:0] UNLK_ADDR_LO = 16'h2AAA;
  localparam logic [7:0]  CODE_KEY1    = 8'hAA;
  localparam logic [7:0]  CODE_KEY2    = 8'h55;
  localparam logic [7:0]  CODE_PROG    = 8'hA0;
  localparam logic [7:0]  CODE_SECID   = 8'hA5;
  localparam logic [7:0]  CODE_ERASE   = 8'h80;
  localparam logic [7:0]  CODE_SECT    = 8'h30;
  localparam logic [7:0]  CODE_BLK     = 8'h50;
  localparam logic [7:0]  CODE_CHIP    = 8'h10;

  localparam int BIT_TOGGLE = 6;
  localparam int BIT_POLL   = 7;
endpackage

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_poll_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 16,
  parameter int IW = 3
) (
  input  logic [1:0]    op,
  input  logic          secid,
  input  logic [IW-1:0] idx,
  input  logic [AW-1:0] tgt_addr,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic          cmd_last
);
  localparam logic [AW-1:0] A_HI = AW'(UNLK_ADDR_HI);
  localparam logic [AW-1:0] A_LO = AW'(UNLK_ADDR_LO);

  function automatic logic [DW-1:0] code(input logic [7:0] c);
    return DW'(c);
  endfunction

  always_comb begin
    cmd_addr = A_HI;
    cmd_data = code(CODE_KEY1);
    cmd_last = 1'b0;
    if (nor_op_e'(op) == OP_PROG) begin
      case (idx)
        IW'(0): begin cmd_addr = A_HI; cmd_data = code(CODE_KEY1); end
        IW'(1): begin cmd_addr = A_LO; cmd_data = code(CODE_KEY2); end
        IW'(2): begin
          cmd_addr = A_HI;
          cmd_data = secid ? code(CODE_SECID) : code(CODE_PROG);
        end
        default: begin cmd_addr = tgt_addr; cmd_data = wdata; cmd_last = 1'b1; end
      endcase
    end else begin
      case (idx)
        IW'(0): begin cmd_addr = A_HI; cmd_data = code(CODE_KEY1); end
        IW'(1): begin cmd_addr = A_LO; cmd_data = code(CODE_KEY2); end
        IW'(2): begin cmd_addr = A_HI; cmd_data = code(CODE_ERASE); end
        IW'(3): begin cmd_addr = A_HI; cmd_data = code(CODE_KEY1); end
        IW'(4): begin cmd_addr = A_LO; cmd_data = code(CODE_KEY2); end
        default: begin
          cmd_last = 1'b1;
          case (nor_op_e'(op))
            OP_SECT: begin cmd_addr = tgt_addr; cmd_data = code(CODE_SECT); end
            OP_BLK:  begin cmd_addr = tgt_addr; cmd_data = code(CODE_BLK); end
            default: begin cmd_addr = A_HI;     cmd_data = code(CODE_CHIP); end
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/nor_status_eval.sv
module nor_status_eval (
  input  logic use_toggle,
  input  logic exp_poll,
  input  logic prev_tog,
  input  logic cur_tog,
  input  logic cur_poll,
  output logic hit
);
  logic settled;
  logic matched;

  assign settled = (prev_tog == cur_tog);
  assign matched = (cur_poll == exp_poll);
  assign hit     = use_toggle ? settled : matched;
endmodule

// File: rtl/nor_poll_timer.sv
module nor_poll_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          bump,
  input  logic [TW-1:0] limit,
  output logic          last
);
  logic [TW-1:0] cnt_q;

  assign last = ({1'b0, cnt_q} + (TW+1)'(1)) >= {1'b0, limit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (bump) cnt_q <= cnt_q + TW'(1);
  end
endmodule

// File: rtl/nor_wr_poller.sv
module nor_wr_poller
  import nor_poll_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 16,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic          req_secid,
  input  logic          req_toggle,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic [TW-1:0] cfg_limit,
  output logic          done_valid,
  output logic          done_err,
  output logic          bus_valid,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ready,
  input  logic [DW-1:0] bus_rdata
);
  localparam int IW = 3;

  poll_st_e      st_q;
  logic [IW-1:0] idx_q;
  logic [1:0]    op_q;
  logic          sec_q;
  logic          tog_q;
  logic [AW-1:0] tgt_q;
  logic [DW-1:0] wd_q;
  logic          prev_q;
  logic          err_q;

  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;
  logic          cmd_last;
  logic          hit;
  logic          hs;
  logic          exp_poll;
  logic          fail;
  logic          tmr_last;
  logic          start;

  nor_cmd_seq #(.AW(AW), .DW(DW), .IW(IW)) u_seq (
    .op       (op_q),
    .secid    (sec_q),
    .idx      (idx_q),
    .tgt_addr (tgt_q),
    .wdata    (wd_q),
    .cmd_addr (cmd_addr),
    .cmd_data (cmd_data),
    .cmd_last (cmd_last)
  );

  assign exp_poll = (nor_op_e'(op_q) == OP_PROG) ? wd_q[BIT_POLL] : 1'b1;

  nor_status_eval u_eval (
    .use_toggle (tog_q),
    .exp_poll   (exp_poll),
    .prev_tog   (prev_q),
    .cur_tog    (bus_rdata[BIT_TOGGLE]),
    .cur_poll   (bus_rdata[BIT_POLL]),
    .hit        (hit)
  );

  assign req_ready = (st_q == S_IDLE);
  assign start     = req_valid && req_ready;
  assign bus_valid = (st_q == S_CMD) || (st_q == S_POLL_A) || (st_q == S_POLL_B) ||
                     (st_q == S_VER_A) || (st_q == S_VER_B);
  assign bus_we    = (st_q == S_CMD);
  assign bus_addr  = (st_q == S_CMD) ? cmd_addr : tgt_q;
  assign bus_wdata = (st_q == S_CMD) ? cmd_data : '0;
  assign hs        = bus_valid && bus_ready;
  assign done_valid = (st_q == S_DONE);
  assign done_err   = (st_q == S_DONE) && err_q;

  // A check fails on a read that does not show a finished status, except
  // for the first read of a toggle pair, which only sets the reference.
  always_comb begin
    fail = 1'b0;
    if (hs) begin
      case (st_q)
        S_POLL_A: fail = !tog_q && !hit;
        S_POLL_B, S_VER_A, S_VER_B: fail = !hit;
        default: fail = 1'b0;
      endcase
    end
  end

  nor_poll_timer #(.TW(TW)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start),
    .bump  (fail),
    .limit (cfg_limit),
    .last  (tmr_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      idx_q  <= '0;
      op_q   <= '0;
      sec_q  <= 1'b0;
      tog_q  <= 1'b0;
      tgt_q  <= '0;
      wd_q   <= '0;
      prev_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (start) begin
            st_q  <= S_CMD;
            idx_q <= '0;
            op_q  <= req_op;
            sec_q <= req_secid && (nor_op_e'(req_op) == OP_PROG);
            tog_q <= req_toggle || (req_secid && (nor_op_e'(req_op) == OP_PROG));
            tgt_q <= req_addr;
            wd_q  <= req_data;
            err_q <= 1'b0;
          end
        end
        S_CMD: begin
          if (hs) begin
            if (cmd_last) st_q <= S_POLL_A;
            else          idx_q <= idx_q + IW'(1);
          end
        end
        S_POLL_A, S_POLL_B, S_VER_A, S_VER_B: begin
          if (hs) begin
            prev_q <= bus_rdata[BIT_TOGGLE];
            if (fail) begin
              if (tmr_last) begin
                st_q  <= S_DONE;
                err_q <= 1'b1;
              end else begin
                st_q <= S_POLL_A;
              end
            end else begin
              case (st_q)
                S_POLL_A: st_q <= tog_q ? S_POLL_B : S_VER_A;
                S_POLL_B: st_q <= S_VER_A;
                S_VER_A:  st_q <= S_VER_B;
                default:  st_q <= S_DONE;
              endcase
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nor_wr_poller_chk.sv
module nor_wr_poller_chk #(
  parameter int AW = 22,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          done_valid,
  input logic          bus_valid,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_ready,
  input logic [AW-1:0] tgt_addr
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_valid);

  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_read_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_we) |-> (bus_addr == tgt_addr));

  assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  assert_done_no_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> !bus_valid);

  assert_hold_stalled_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=>
      (bus_valid && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));
endmodule

bind nor_wr_poller nor_wr_poller_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .done_valid (done_valid),
  .bus_valid  (bus_valid),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_ready  (bus_ready),
  .tgt_addr   (tgt_q)
);

// File: tb/nor_wr_poller_tb.sv
module nor_wr_poller_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = '0;
  logic          req_secid = 1'b0;
  logic          req_toggle = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [TW-1:0] cfg_limit = '0;
  logic          done_valid;
  logic          done_err;
  logic          bus_valid;
  logic          bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_ready = 1'b1;
  logic [DW-1:0] bus_rdata;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  // bench-side configuration of the flash model
  int            c_op = 0;
  logic [DW-1:0] c_data = '0;
  int            c_busy = 0;
  int            c_glitch = -1;
  bit            stall_en = 1'b0;
  int            cyc = 0;

  // flash model state, written only at the clock edge
  int            m_busy;
  int            m_bidx;
  logic          m_last6;
  int            m_wn;
  int            m_reads;
  int            m_ready_reads;
  int            m_addr_err;
  logic [AW-1:0] m_wa [0:7];
  logic [DW-1:0] m_wd [0:7];

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_wr_poller #(.AW(AW), .DW(DW), .TW(TW)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_op     (req_op),
    .req_secid  (req_secid),
    .req_toggle (req_toggle),
    .req_addr   (req_addr),
    .req_data   (req_data),
    .cfg_limit  (cfg_limit),
    .done_valid (done_valid),
    .done_err   (done_err),
    .bus_valid  (bus_valid),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_ready  (bus_ready),
    .bus_rdata  (bus_rdata)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    bus_ready <= stall_en ? ((cyc % 3) != 0) : 1'b1;
  end

  always_comb begin
    logic tb;
    logic g;
    tb = (c_op == 0) ? c_data[7] : 1'b1;
    g = (m_bidx == c_glitch);
    bus_rdata = '0;
    if (m_busy > 0) begin
      bus_rdata[6] = g ? m_last6 : ~m_last6;
      bus_rdata[2] = (c_op != 0) ? bus_rdata[6] : 1'b0;
      bus_rdata[7] = g ? tb : ~tb;
    end else begin
      bus_rdata = (c_op == 0) ? c_data : 16'hFFFF;
    end
  end

  always @(posedge clk) begin
    if (req_valid && req_ready) begin
      m_busy <= c_busy;
      m_bidx <= 0;
      m_last6 <= 1'b0;
      m_wn <= 0;
      m_reads <= 0;
      m_ready_reads <= 0;
      m_addr_err <= 0;
    end else if (bus_valid && bus_ready) begin
      if (bus_we) begin
        if (m_wn < 8) begin
          m_wa[m_wn] <= bus_addr;
          m_wd[m_wn] <= bus_wdata;
        end
        m_wn <= m_wn + 1;
      end else begin
        m_reads <= m_reads + 1;
        if (bus_addr != req_addr) m_addr_err <= m_addr_err + 1;
        if (m_busy > 0) begin
          m_busy <= m_busy - 1;
          m_bidx <= m_bidx + 1;
          m_last6 <= bus_rdata[6];
        end else begin
          m_ready_reads <= m_ready_reads + 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic run_op(input int op, input bit sec, input bit tog,
                        input logic [AW-1:0] addr, input logic [DW-1:0] data,
                        input int nb, input int gl, input int lim,
                        input bit exp_err, input int exp_reads);
    logic [AW-1:0] ea [0:5];
    logic [DW-1:0] ed [0:5];
    int ne;
    int k;
    bit seen;
    bit bad;
    ne = (op == 0) ? 4 : 6;
    ea[0] = 16'h5555; ed[0] = 16'h00AA;
    ea[1] = 16'h2AAA; ed[1] = 16'h0055;
    if (op == 0) begin
      ea[2] = 16'h5555; ed[2] = sec ? 16'h00A5 : 16'h00A0;
      ea[3] = addr;     ed[3] = data;
      ea[4] = '0; ed[4] = '0; ea[5] = '0; ed[5] = '0;
    end else begin
      ea[2] = 16'h5555; ed[2] = 16'h0080;
      ea[3] = 16'h5555; ed[3] = 16'h00AA;
      ea[4] = 16'h2AAA; ed[4] = 16'h0055;
      case (op)
        1: begin ea[5] = addr; ed[5] = 16'h0030; end
        2: begin ea[5] = addr; ed[5] = 16'h0050; end
        default: begin ea[5] = 16'h5555; ed[5] = 16'h0010; end
      endcase
    end
    c_op = op; c_data = data; c_busy = nb; c_glitch = gl;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_secid = sec; req_toggle = tog;
    req_addr = addr; req_data = data; cfg_limit = TW'(lim);
    k = 0;
    while (!req_ready && k < 100) begin @(negedge clk); k++; end
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R1 ready low after accept", int'(req_ready), 0);
    seen = 1'b0;
    for (int w = 0; w < 20000; w++) begin
      if (done_valid) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    check(seen, "R11 done pulse seen", int'(seen), 1);
    if (!seen) return;
    check(done_err == exp_err, "R10 done_err", int'(done_err), int'(exp_err));
    check(m_wn == ne, "R2 R3 R4 write count", m_wn, ne);
    bad = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (i < ne && (m_wa[i] != ea[i] || m_wd[i] != ed[i])) begin
        bad = 1'b1;
        $display("FAIL R2 R3 R4 R9 write %0d actual=%h/%h expected=%h/%h",
                 i, m_wa[i], m_wd[i], ea[i], ed[i]);
      end
    end
    tests++;
    if (bad) fails++;
    check(m_addr_err == 0, "R5 status read address", m_addr_err, 0);
    if (!exp_err) begin
      check(m_busy == 0, "R8 no early pass, busy reads left", m_busy, 0);
      check(m_ready_reads >= 2, "R8 confirming reads", m_ready_reads, 2);
    end
    if (exp_reads >= 0)
      check(m_reads == exp_reads, "R6 R7 R9 R10 read count", m_reads, exp_reads);
    @(negedge clk);
    check(done_valid == 1'b0, "R11 pulse one cycle", int'(done_valid), 0);
    check(req_ready == 1'b1, "R1 idle after done", int'(req_ready), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int nbs [0:3];
    nbs[0] = 0; nbs[1] = 1; nbs[2] = 3; nbs[3] = 6;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
    check(bus_valid == 1'b0, "R1 reset bus idle", int'(bus_valid), 0);
    check(done_valid == 1'b0, "R11 reset no done", int'(done_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep: op x polling mode x busy length x glitch x stall
    for (int op = 0; op < 4; op++) begin
      for (int tg = 0; tg < 2; tg++) begin
        for (int bi = 0; bi < 4; bi++) begin
          for (int gi = 0; gi < 2; gi++) begin
            int nb;
            int gl;
            logic [15:0] d;
            nb = nbs[bi];
            gl = (gi == 0) ? -1 : nb - 2;
            if (gi == 1 && nb < 2) continue;
            d = 16'(16'h1234 + op * 16'h0101 + bi * 16'h0040 + gi * 16'h0080);
            stall_en = ((op + bi + gi) % 2) == 1;
            // R6 toggle / R7 data polling / R8 glitch rejection
            run_op(op, 1'b0, tg[0], 16'(16'h0400 + op * 16'h0100 + bi), d, nb, gl,
                   200, 1'b0, (tg == 0) ? nb + 3 : -1);
          end
        end
      end
    end
    stall_en = 1'b0;

    // glitch at the very first busy read, long busy phase
    run_op(0, 1'b0, 1'b0, 16'h0777, 16'h00FF, 6, 0, 200, 1'b0, 9);
    run_op(1, 1'b0, 1'b1, 16'h0888, 16'h0000, 6, 0, 200, 1'b0, -1);

    // R10 timeouts: data polling costs one read per check, toggle two
    run_op(0, 1'b0, 1'b0, 16'h0100, 16'h0055, 1000, -1, 3, 1'b1, 3);
    run_op(2, 1'b0, 1'b1, 16'h0200, 16'h0000, 1000, -1, 3, 1'b1, 6);
    run_op(3, 1'b0, 1'b0, 16'h0300, 16'h0000, 1000, -1, 0, 1'b1, 1);
    run_op(1, 1'b0, 1'b1, 16'h0310, 16'h0000, 1000, -1, 1, 1'b1, 2);

    // R9 security-ID program forces toggle: twice the data-polling count
    run_op(0, 1'b1, 1'b0, 16'h0020, 16'h8001, 1000, -1, 4, 1'b1, 8);
    run_op(0, 1'b1, 1'b0, 16'h0021, 16'h0081, 3, -1, 200, 1'b0, -1);
    // R9 the flag has no effect on an erase: data polling stays
    run_op(1, 1'b1, 1'b0, 16'h0022, 16'h0000, 1000, -1, 4, 1'b1, 4);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule